// File: doc/BRIEF.md
# Static Memory Strobe Timer

This block drives the control pins of an asynchronous static memory for one access at a time. A requester offers an access with address, write data, byte enables, a chip-select number and a direction flag. The block accepts it when it is idle, then holds the address and byte selects for the length of the access. It shapes the active-low chip select and the active-low read or write strobe from setup, pulse and cycle counts, all counted in clock cycles.

The counts normally come from a set of programmed timing inputs, one set for reads and one for writes. When the slow-clock input is high, a fixed minimal timing set is used in place of the programmed one, whichever chip select is addressed. The slow-clock input is sampled only when an access is accepted. For a read, the memory data is captured on the clock edge where the read strobe goes high again. A one-clock done pulse marks the end of every access.

Top module: `sram_strobe_timer`

## Requirements
- R1: After reset, and whenever no access is running, every chip-select line, the read strobe, the write strobe and every byte-select line is high, `req_ready` is 1 and `acc_done` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The access then lasts exactly C clock cycles (access cycles 0 to C-1, with cycle 0 the one right after the accepting edge), and `req_ready` is 0 during them. `acc_done` is 1 for exactly the one cycle that follows them.
- R3: For a read, `mem_rd_n` is low in access cycle k exactly when setup <= k < setup + pulse, using the read-strobe counts. `mem_we_n` stays high.
- R4: For a write, `mem_we_n` is low in access cycle k exactly when setup <= k < setup + pulse, using the write-strobe counts. `mem_rd_n` stays high and `mem_wdata` carries the accepted write data.
- R5: Only the chip-select line whose index equals the accepted `req_cs` goes low. It is low in the cycles set by the chip-select setup and pulse of the access's direction, and at most one line is low at any time.
- R6: A programmed pulse count of zero, or a cycle count of zero, is used as one.
- R7: When setup + pulse exceeds the cycle count, the strobe or chip select goes high at the end of the last access cycle.
- R8: With slow-clock mode sampled high, a read uses these counts and ignores the programmed ones: strobe setup 1, strobe pulse 1, chip-select setup 0, chip-select pulse 2, cycle 2.
- R9: With slow-clock mode sampled high, a write uses these counts and ignores the programmed ones: strobe setup 1, strobe pulse 1, chip-select setup 0, chip-select pulse 3, cycle 3.
- R10: The slow-clock timing applies in the same way to every chip-select index.
- R11: The slow-clock input is sampled only on the accepting edge. A change during an access neither alters nor shortens that access.
- R12: `mem_addr` holds the accepted address from access cycle 0 until the next accept. `mem_bs_n` equals the bitwise inverse of the accepted byte enables for all C access cycles.
- R13: A read captures `mem_rdata` on the clock edge that ends the last cycle in which `mem_rd_n` is low. The captured value is on `rd_data` while `acc_done` is 1, and it is held until the next such capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_mode | input | 1 | Selects the fixed slow timing set; sampled at accept |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cs | input | CS_W | Chip-select index |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | BE_W | Byte enables, active high |
| rd_strb_setup | input | CNT_W | Programmed read-strobe setup |
| rd_strb_pulse | input | CNT_W | Programmed read-strobe pulse |
| rd_cs_setup | input | CNT_W | Programmed chip-select setup for reads |
| rd_cs_pulse | input | CNT_W | Programmed chip-select pulse for reads |
| rd_cycle | input | CNT_W | Programmed read cycle length |
| wr_strb_setup | input | CNT_W | Programmed write-strobe setup |
| wr_strb_pulse | input | CNT_W | Programmed write-strobe pulse |
| wr_cs_setup | input | CNT_W | Programmed chip-select setup for writes |
| wr_cs_pulse | input | CNT_W | Programmed chip-select pulse for writes |
| wr_cycle | input | CNT_W | Programmed write cycle length |
| req_ready | output | 1 | Idle and able to accept |
| acc_done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | DATA_W | Captured read data |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_bs_n | output | BE_W | Active-low byte selects |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The assertions assume that reset is high on the first clock edge. They also assume that `req_cs` always names an existing chip select, which holds by width at the default of four lines. The programmed counts and the slow-clock input may change at any time, because the block copies them at accept. The stimulus changes all inputs on the falling edge only and drops `req_valid` right after the accepting edge. It gives every read whose data is checked a strobe setup smaller than its cycle count, so that the strobe does assert.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

    parameter int CNT_W = 6;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t setup;
        cnt_t pulse;
    } window_t;

    typedef struct packed {
        window_t strb;
        window_t cs;
        cnt_t    cycle;
    } timing_t;

    function automatic cnt_t at_least_one(cnt_t v);
        return (v == '0) ? cnt_t'(1) : v;
    endfunction

    function automatic timing_t slow_timing(logic is_write);
        timing_t t;
        t.strb.setup = cnt_t'(1);
        t.strb.pulse = cnt_t'(1);
        t.cs.setup   = cnt_t'(0);
        t.cs.pulse   = is_write ? cnt_t'(3) : cnt_t'(2);
        t.cycle      = is_write ? cnt_t'(3) : cnt_t'(2);
        return t;
    endfunction

    function automatic timing_t normalise(timing_t t);
        timing_t r;
        r = t;
        r.strb.pulse = at_least_one(t.strb.pulse);
        r.cs.pulse   = at_least_one(t.cs.pulse);
        r.cycle      = at_least_one(t.cycle);
        return r;
    endfunction

endpackage

// File: rtl/strobe_timing_sel.sv
module strobe_timing_sel
    import strobe_pkg::*;
(
    input  logic    slow,
    input  logic    is_write,
    input  timing_t prog_rd,
    input  timing_t prog_wr,
    output timing_t chosen
);

    always_comb begin
        if (slow)
            chosen = slow_timing(is_write);
        else if (is_write)
            chosen = normalise(prog_wr);
        else
            chosen = normalise(prog_rd);
    end

endmodule

// File: rtl/strobe_sequencer.sv
module strobe_sequencer
    import strobe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  timing_t t_in,
    output logic    busy,
    output cnt_t    cnt,
    output logic    last,
    output logic    done,
    output timing_t t_lat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            done  <= 1'b0;
            t_lat <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                cnt   <= '0;
                t_lat <= t_in;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + cnt_t'(1);
                end
            end
        end
    end

    assign last = busy && (cnt == t_lat.cycle - cnt_t'(1));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    timing_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(last)) |-> $stable(t_lat));

    // R2
    no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

endmodule

// File: rtl/strobe_window.sv
module strobe_window
    import strobe_pkg::*;
(
    input  logic    busy,
    input  cnt_t    cnt,
    input  logic    last,
    input  window_t w,
    output logic    active,
    output logic    ending
);

    logic [CNT_W:0] k_ext;
    logic [CNT_W:0] stop_at;

    always_comb begin
        k_ext   = {1'b0, cnt};
        stop_at = {1'b0, w.setup} + {1'b0, w.pulse};
        active  = busy && (cnt >= w.setup) && (k_ext < stop_at);
        ending  = active && (((k_ext + (CNT_W+1)'(1)) >= stop_at) || last);
    end

endmodule

// File: rtl/sram_strobe_timer.sv
module sram_strobe_timer
    import strobe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2,
    parameter int NUM_CS = 4,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_clk_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic [CNT_W-1:0]  rd_strb_setup,
    input  logic [CNT_W-1:0]  rd_strb_pulse,
    input  logic [CNT_W-1:0]  rd_cs_setup,
    input  logic [CNT_W-1:0]  rd_cs_pulse,
    input  logic [CNT_W-1:0]  rd_cycle,
    input  logic [CNT_W-1:0]  wr_strb_setup,
    input  logic [CNT_W-1:0]  wr_strb_pulse,
    input  logic [CNT_W-1:0]  wr_cs_setup,
    input  logic [CNT_W-1:0]  wr_cs_pulse,
    input  logic [CNT_W-1:0]  wr_cycle,
    output logic              req_ready,
    output logic              acc_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_we_n,
    output logic [BE_W-1:0]   mem_bs_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    timing_t prog_rd, prog_wr, chosen, t_lat;
    logic    busy, last, accept;
    cnt_t    cnt;
    logic    is_write;
    logic [CS_W-1:0] cs_sel;
    logic [BE_W-1:0] be_lat;
    logic [1:0] win_act, win_end;

    assign prog_rd = '{strb: '{rd_strb_setup, rd_strb_pulse},
                       cs:   '{rd_cs_setup, rd_cs_pulse}, cycle: rd_cycle};
    assign prog_wr = '{strb: '{wr_strb_setup, wr_strb_pulse},
                       cs:   '{wr_cs_setup, wr_cs_pulse}, cycle: wr_cycle};

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    strobe_timing_sel u_sel (
        .slow     (slow_clk_mode),
        .is_write (req_write),
        .prog_rd  (prog_rd),
        .prog_wr  (prog_wr),
        .chosen   (chosen)
    );

    strobe_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .t_in  (chosen),
        .busy  (busy),
        .cnt   (cnt),
        .last  (last),
        .done  (acc_done),
        .t_lat (t_lat)
    );

    // index 0: data strobe, index 1: chip select
    for (genvar g = 0; g < 2; g++) begin : g_win
        strobe_window u_win (
            .busy   (busy),
            .cnt    (cnt),
            .last   (last),
            .w      ((g == 0) ? t_lat.strb : t_lat.cs),
            .active (win_act[g]),
            .ending (win_end[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            is_write  <= 1'b0;
            cs_sel    <= '0;
            be_lat    <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            rd_data   <= '0;
        end else begin
            if (accept) begin
                is_write  <= req_write;
                cs_sel    <= req_cs;
                be_lat    <= req_be;
                mem_addr  <= req_addr;
                mem_wdata <= req_wdata;
            end
            if (!is_write && win_end[0])
                rd_data <= mem_rdata;
        end
    end

    assign mem_rd_n = !(win_act[0] && !is_write);
    assign mem_we_n = !(win_act[0] && is_write);
    assign mem_bs_n = busy ? ~be_lat : '1;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign mem_cs_n[i] = !(win_act[1] && (cs_sel == CS_W'(i)));
    end

    // R5
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_we_n));

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (&mem_cs_n && mem_rd_n && mem_we_n && &mem_bs_n));

    // R12
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> ($stable(mem_addr) && $stable(mem_bs_n)));

endmodule

// File: tb/tb_sram_strobe_timer.sv
module tb_sram_strobe_timer;
    import strobe_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        slow_clk_mode = 1'b0, req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic [CNT_W-1:0] rss = '0, rsp = '0, rcs = '0, rcp = '0, rcy = '0;
    logic [CNT_W-1:0] wss = '0, wsp = '0, wcs = '0, wcp = '0, wcy = '0;
    logic        req_ready, acc_done, mem_rd_n, mem_we_n;
    logic [15:0] rd_data, mem_wdata;
    logic [3:0]  mem_cs_n;
    logic [1:0]  mem_bs_n;
    logic [23:0] mem_addr;
    logic [15:0] mem_rdata = 16'h0A5C;

    sram_strobe_timer dut (
        .clk(clk), .rst(rst), .slow_clk_mode(slow_clk_mode),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_strb_setup(rss), .rd_strb_pulse(rsp), .rd_cs_setup(rcs),
        .rd_cs_pulse(rcp), .rd_cycle(rcy),
        .wr_strb_setup(wss), .wr_strb_pulse(wsp), .wr_cs_setup(wcs),
        .wr_cs_pulse(wcp), .wr_cycle(wcy),
        .req_ready(req_ready), .acc_done(acc_done), .rd_data(rd_data),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n),
        .mem_bs_n(mem_bs_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // memory data changes shortly after every rising edge
    always @(posedge clk) begin
        #1;
        mem_rdata = mem_rdata + 16'h1357;
    end

    typedef struct {
        logic [3:0]  cs_n;
        logic        rd_n, we_n;
        logic [1:0]  bs_n;
        logic [23:0] addr;
        logic        done, ready, rd_last, chk_wd, chk_rd;
        logic [15:0] wdata;
        string       tag;
    } exp_t;

    typedef struct { int ds; int dp; int cs_s; int cs_p; int cyc; } tim_t;

    exp_t q[$];
    exp_t e;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [15:0] exp_rdata = '0;

    function automatic bit in_win(int k, int s, int p);
        return (k >= s) && (k < s + p);
    endfunction

    task automatic do_access(input bit wr, input int cs, input logic [23:0] addr,
                             input logic [15:0] wd, input logic [1:0] be,
                             input tim_t t, input bit flip, input string tag);
        tim_t eff;
        exp_t x;
        @(negedge clk);
        if (wr) begin
            wss = CNT_W'(t.ds); wsp = CNT_W'(t.dp); wcs = CNT_W'(t.cs_s);
            wcp = CNT_W'(t.cs_p); wcy = CNT_W'(t.cyc);
        end else begin
            rss = CNT_W'(t.ds); rsp = CNT_W'(t.dp); rcs = CNT_W'(t.cs_s);
            rcp = CNT_W'(t.cs_p); rcy = CNT_W'(t.cyc);
        end
        req_valid = 1'b1; req_write = wr; req_cs = 2'(cs);
        req_addr = addr; req_wdata = wd; req_be = be;
        if (slow_clk_mode) begin
            eff.ds = 1; eff.dp = 1; eff.cs_s = 0;
            eff.cs_p = wr ? 3 : 2; eff.cyc = wr ? 3 : 2;
        end else begin
            eff = t;
            if (eff.dp == 0) eff.dp = 1;
            if (eff.cs_p == 0) eff.cs_p = 1;
            if (eff.cyc == 0) eff.cyc = 1;
        end
        for (int k = 0; k < eff.cyc; k++) begin
            bit dw, cw;
            dw = in_win(k, eff.ds, eff.dp);
            cw = in_win(k, eff.cs_s, eff.cs_p);
            x.cs_n = 4'hF;
            if (cw) x.cs_n[cs] = 1'b0;
            x.rd_n = !(dw && !wr);
            x.we_n = !(dw && wr);
            x.bs_n = ~be;
            x.addr = addr;
            x.done = 1'b0; x.ready = 1'b0;
            x.rd_last = !wr && dw && ((k == eff.ds + eff.dp - 1) || (k == eff.cyc - 1));
            x.chk_wd = wr; x.chk_rd = 1'b0; x.wdata = wd; x.tag = tag;
            q.push_back(x);
        end
        x.cs_n = 4'hF; x.rd_n = 1'b1; x.we_n = 1'b1; x.bs_n = 2'b11;
        x.addr = addr; x.done = 1'b1; x.ready = 1'b1; x.rd_last = 1'b0;
        x.chk_wd = wr; x.chk_rd = !wr; x.wdata = wd; x.tag = tag;
        q.push_back(x);
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) slow_clk_mode = !slow_clk_mode;
        repeat (eff.cyc) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #3;
        if (!rst && !finished) begin
            if (q.size() > 0) begin
                bit ok;
                e = q.pop_front();
                ok = (mem_cs_n === e.cs_n) && (mem_rd_n === e.rd_n) &&
                     (mem_we_n === e.we_n) && (mem_bs_n === e.bs_n) &&
                     (mem_addr === e.addr) && (acc_done === e.done) &&
                     (req_ready === e.ready);
                if (e.chk_wd) ok = ok && (mem_wdata === e.wdata);
                if (e.chk_rd) ok = ok && (rd_data === exp_rdata);
                checks++;
                if (!ok) begin
                    fails++;
                    $display("FAIL %s: got cs=%h rd=%b we=%b bs=%h addr=%h done=%b rdy=%b wd=%h rdat=%h exp cs=%h rd=%b we=%b bs=%h addr=%h done=%b rdy=%b wd=%h rdat=%h",
                             e.tag, mem_cs_n, mem_rd_n, mem_we_n, mem_bs_n, mem_addr,
                             acc_done, req_ready, mem_wdata, rd_data,
                             e.cs_n, e.rd_n, e.we_n, e.bs_n, e.addr, e.done, e.ready,
                             e.wdata, exp_rdata);
                end
                if (e.rd_last) exp_rdata = mem_rdata;
            end else begin
                checks++;
                if (!(mem_cs_n === 4'hF && mem_rd_n === 1'b1 && mem_we_n === 1'b1 &&
                      mem_bs_n === 2'b11 && req_ready === 1'b1 && acc_done === 1'b0)) begin
                    fails++;
                    $display("FAIL R1 idle: got cs=%h rd=%b we=%b bs=%h rdy=%b done=%b exp cs=f rd=1 we=1 bs=3 rdy=1 done=0",
                             mem_cs_n, mem_rd_n, mem_we_n, mem_bs_n, req_ready, acc_done);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (!(mem_cs_n === 4'hF && mem_rd_n === 1'b1 && mem_we_n === 1'b1 &&
              req_ready === 1'b1 && acc_done === 1'b0 && rd_data === 16'h0)) begin
            fails++;
            $display("FAIL R1 reset: got cs=%h rd=%b we=%b rdy=%b done=%b rdat=%h exp cs=f rd=1 we=1 rdy=1 done=0 rdat=0",
                     mem_cs_n, mem_rd_n, mem_we_n, req_ready, acc_done, rd_data);
        end
        // R2 R3 R5 R13: programmed read
        do_access(1'b0, 1, 24'h12_3456, 16'h0, 2'b11, '{2, 3, 1, 5, 7}, 1'b0, "R3/R5/R13");
        // R4 R12: programmed write with partial byte enables
        do_access(1'b1, 2, 24'hAB_CDEF, 16'hBEEF, 2'b01, '{1, 2, 0, 4, 5}, 1'b0, "R4/R12");
        // R2: back-to-back reads on other chip select
        do_access(1'b0, 0, 24'h00_0010, 16'h0, 2'b10, '{0, 1, 0, 2, 2}, 1'b0, "R2");
        // R6: zero pulse counts
        do_access(1'b0, 3, 24'h00_0020, 16'h0, 2'b11, '{1, 0, 0, 0, 3}, 1'b0, "R6");
        // R6: zero cycle count on a write
        do_access(1'b1, 1, 24'h00_0030, 16'h1234, 2'b11, '{0, 1, 0, 1, 0}, 1'b0, "R6");
        // R7: strobes clipped by cycle end
        do_access(1'b0, 2, 24'h00_0040, 16'h0, 2'b11, '{3, 6, 2, 9, 5}, 1'b0, "R7");
        do_access(1'b1, 0, 24'h00_0050, 16'h5A5A, 2'b10, '{2, 7, 1, 8, 4}, 1'b0, "R7");
        // R8 R9 R10: slow mode over varied chip selects, odd programmed values
        slow_clk_mode = 1'b1;
        do_access(1'b0, 0, 24'h00_0060, 16'h0, 2'b11, '{4, 5, 3, 6, 12}, 1'b0, "R8");
        do_access(1'b1, 3, 24'h00_0070, 16'hC0DE, 2'b01, '{5, 2, 2, 4, 9}, 1'b0, "R9");
        do_access(1'b0, 2, 24'h00_0080, 16'h0, 2'b10, '{0, 9, 0, 9, 20}, 1'b0, "R10");
        do_access(1'b1, 1, 24'h00_0090, 16'h7777, 2'b11, '{0, 0, 0, 0, 0}, 1'b0, "R10");
        // R11: slow mode drops during a slow access, then rises during a programmed one
        do_access(1'b0, 1, 24'h00_00A0, 16'h0, 2'b11, '{2, 3, 1, 5, 7}, 1'b1, "R11");
        do_access(1'b0, 3, 24'h00_00B0, 16'h0, 2'b11, '{0, 2, 0, 3, 4}, 1'b1, "R11");
        do_access(1'b1, 0, 24'h00_00C0, 16'h9999, 2'b11, '{3, 2, 1, 4, 6}, 1'b0, "R11");
        slow_clk_mode = 1'b0;
        // R13: capture at a strobe that ends before cycle end
        do_access(1'b0, 0, 24'h00_00D0, 16'h0, 2'b11, '{1, 2, 0, 6, 6}, 1'b0, "R13");
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule